// File: doc/BRIEF.md
# String Compare Execution Unit

This unit runs a memory-to-memory comparison of two strings of equal element width. A start pulse loads a source index, a destination index and an element count, along with the element width (8, 16 or 32 bits), the address width (16 or 32 bits), the stepping direction and the repeat mode. The unit then fetches one element at each index through a byte-wide read port with a ready handshake. It subtracts the destination element from the source element and keeps only the arithmetic flags from that difference. Both indices then move by the same signed step.

In single mode exactly one comparison is made and the count is left alone. In the two repeat modes the count drops by one after each comparison. The run continues while the count is nonzero and the zero flag matches the mode. When 16-bit addressing is selected, the unit refuses any element that would run past address 0xFFFF. In that case it raises a fault and leaves the registers as they were before that element. A one-cycle done pulse marks the end of every run.

Top module: `strcmp_unit`

## Requirements
- R1: The width code `elem_sz` selects 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3). An element is read one byte per handshake from its index upward, the lowest address holding the least significant byte.
- R2: The unit computes source minus destination at the element width and stores only the flags. The `flags` bits are: bit 0 borrow out (CF), bit 1 even parity of result bits 7:0 (PF), bit 2 borrow out of bit 3 (AF), bit 3 result zero (ZF), bit 4 result sign (SF), bit 5 signed overflow (OF).
- R3: After each comparison both indices advance by the element size in bytes. They advance upward when `dir_down` is 0 and downward when it is 1.
- R4: With `addr_wide` = 0, only bits 15:0 of both indices and of the count are used, wrapping within 16 bits. Their bits 31:16 stay as loaded, and `mem_addr[31:16]` is 0.
- R5: `rep_mode` 0 (or 3) makes one comparison and leaves the count unchanged. Mode 1 repeats while ZF is 1, and mode 2 repeats while ZF is 0. In both repeat modes the count drops by one per comparison, and the run stops once the decremented count is zero or the ZF condition fails.
- R6: In a repeat mode, a count of zero at start makes the run end at once. No read takes place, and the indices, count and flags keep their prior values.
- R7: With `addr_wide` = 0, an element that would reach past 0xFFFF at either index raises `fault`. That element causes no read and no update, and the run ends. `fault` stays high until the next accepted start.
- R8: `done` is high for exactly one cycle per run. A `start` that arrives while a run is in progress is ignored.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when idle |
| elem_sz | input | 2 | Element width code |
| addr_wide | input | 1 | 1: 32-bit indices, 0: 16-bit |
| dir_down | input | 1 | 1: indices step downward |
| rep_mode | input | 2 | 0 single, 1 repeat while equal, 2 repeat while unequal |
| src_init | input | 32 | Source index loaded at start |
| dst_init | input | 32 | Destination index loaded at start |
| cnt_init | input | 32 | Count loaded at start |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_ready | input | 1 | Read data valid; consumes the request |
| mem_rdata | input | 8 | Read data byte |
| src_idx | output | 32 | Current source index |
| dst_idx | output | 32 | Current destination index |
| cnt | output | 32 | Current count |
| flags | output | 6 | Flags, encoded as in R2 |
| done | output | 1 | One-cycle end-of-run pulse |
| fault | output | 1 | Address-range fault of the last run |

## Verification
A zero-count repeat run raises `done` one cycle after the start edge, and a range fault raises it two cycles after. A run with reads has no fixed length, because the bench memory inserts random wait cycles before each `mem_ready`. The bench therefore samples on falling edges and waits for `done`, then compares the indices, count, flags and fault against its own model at that same falling edge. It checks one falling edge later that `done` has dropped. Address stability during wait cycles is checked at every falling edge where the request is still outstanding.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_RD_SRC = 3'd2,
        ST_RD_DST = 3'd3,
        ST_EXEC   = 3'd4
    } st_e;

    localparam logic [1:0] RP_NONE = 2'd0;
    localparam logic [1:0] RP_EQ   = 2'd1;
    localparam logic [1:0] RP_NE   = 2'd2;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;
    localparam int FL_W  = 6;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/strcmp_alu.sv
module strcmp_alu
    import strcmp_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0] a_i,
    input  logic [OP_W-1:0] b_i,
    input  logic [1:0]      size_i,
    output logic [FL_W-1:0] flags_o
);

    logic [OP_W:0]   diff;
    logic [OP_W-1:0] mask;
    logic [OP_W-1:0] res;
    logic            a_top, b_top, r_top, borrow;

    always_comb begin
        case (size_i)
            2'd0:    mask = OP_W'(8'hFF);
            2'd1:    mask = OP_W'(16'hFFFF);
            default: mask = '1;
        endcase
        diff = {1'b0, a_i & mask} - {1'b0, b_i & mask};
        res  = diff[OP_W-1:0] & mask;
        case (size_i)
            2'd0: begin
                a_top = a_i[7];  b_top = b_i[7];  r_top = res[7];  borrow = diff[8];
            end
            2'd1: begin
                a_top = a_i[15]; b_top = b_i[15]; r_top = res[15]; borrow = diff[16];
            end
            default: begin
                a_top = a_i[OP_W-1]; b_top = b_i[OP_W-1];
                r_top = res[OP_W-1]; borrow = diff[OP_W];
            end
        endcase
        flags_o        = '0;
        flags_o[FL_CF] = borrow;
        flags_o[FL_PF] = ~^res[7:0];
        flags_o[FL_AF] = a_i[3:0] < b_i[3:0];
        flags_o[FL_ZF] = (res == '0);
        flags_o[FL_SF] = r_top;
        flags_o[FL_OF] = (a_top != b_top) && (r_top != a_top);
    end

endmodule

// File: rtl/strcmp_stepper.sv
module strcmp_stepper #(
    parameter int IDX_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [2:0]       nbytes_i,
    input  logic             down_i,
    input  logic             wide_i,
    output logic [IDX_W-1:0] next_o,
    output logic             oob_o
);

    localparam logic [NARROW_W:0] LIMIT = {1'b0, {NARROW_W{1'b1}}};

    logic [IDX_W-1:0]  step;
    logic [IDX_W-1:0]  sum;
    logic [NARROW_W:0] last_byte;

    always_comb begin
        step      = down_i ? -IDX_W'(nbytes_i) : IDX_W'(nbytes_i);
        sum       = idx_i + step;
        next_o    = wide_i ? sum : {idx_i[IDX_W-1:NARROW_W], sum[NARROW_W-1:0]};
        last_byte = {1'b0, idx_i[NARROW_W-1:0]} + (NARROW_W+1)'(nbytes_i)
                    - (NARROW_W+1)'(1);
        oob_o     = !wide_i && (last_byte > LIMIT);
    end

endmodule

// File: rtl/strcmp_unit.sv
module strcmp_unit
    import strcmp_pkg::*;
#(
    parameter int IDX_W    = 32,
    parameter int NARROW_W = 16,
    parameter int OP_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       elem_sz,
    input  logic             addr_wide,
    input  logic             dir_down,
    input  logic [1:0]       rep_mode,
    input  logic [IDX_W-1:0] src_init,
    input  logic [IDX_W-1:0] dst_init,
    input  logic [IDX_W-1:0] cnt_init,
    output logic             mem_req,
    output logic [IDX_W-1:0] mem_addr,
    input  logic             mem_ready,
    input  logic [7:0]       mem_rdata,
    output logic [IDX_W-1:0] src_idx,
    output logic [IDX_W-1:0] dst_idx,
    output logic [IDX_W-1:0] cnt,
    output logic [FL_W-1:0]  flags,
    output logic             done,
    output logic             fault
);

    localparam int K_W = $clog2(OP_W / 8);

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] cnt;
        logic [OP_W-1:0]  opa;
        logic [OP_W-1:0]  opb;
        logic [K_W-1:0]   k;
        logic [FL_W-1:0]  flags;
        logic             done;
        logic             fault;
        logic [1:0]       size;
        logic             wide;
        logic             down;
        logic [1:0]       rep;
    } regs_t;

    regs_t q, d;

    logic [2:0]            nbytes;
    logic [1:0][IDX_W-1:0] idx_cur, idx_nxt;
    logic [1:0]            oob;
    logic [FL_W-1:0]       alu_flags;
    logic [IDX_W-1:0]      fetch_base, fetch_addr, cnt_dec;
    logic                  cnt_dec_zero, init_zero, rep_on, last_byte, go_on;
    logic                  busy_w, a32_w;

    assign nbytes  = size_bytes(q.size);
    assign idx_cur = {q.dst, q.src};

    for (genvar g = 0; g < 2; g++) begin : g_step
        strcmp_stepper #(.IDX_W(IDX_W), .NARROW_W(NARROW_W)) u_step (
            .idx_i    (idx_cur[g]),
            .nbytes_i (nbytes),
            .down_i   (q.down),
            .wide_i   (q.wide),
            .next_o   (idx_nxt[g]),
            .oob_o    (oob[g])
        );
    end

    strcmp_alu #(.OP_W(OP_W)) u_alu (
        .a_i     (q.opa),
        .b_i     (q.opb),
        .size_i  (q.size),
        .flags_o (alu_flags)
    );

    always_comb begin
        fetch_base = (q.st == ST_RD_DST) ? q.dst : q.src;
        fetch_addr = fetch_base + IDX_W'(q.k);
        mem_req    = (q.st == ST_RD_SRC) || (q.st == ST_RD_DST);
        mem_addr   = q.wide ? fetch_addr
                            : {{(IDX_W-NARROW_W){1'b0}}, fetch_addr[NARROW_W-1:0]};
    end

    always_comb begin
        d            = q;
        d.done       = 1'b0;
        rep_on       = (q.rep == RP_EQ) || (q.rep == RP_NE);
        last_byte    = ({1'b0, q.k} == (nbytes - 3'd1));
        cnt_dec      = q.wide ? (q.cnt - IDX_W'(1))
                              : {q.cnt[IDX_W-1:NARROW_W], q.cnt[NARROW_W-1:0] - NARROW_W'(1)};
        cnt_dec_zero = q.wide ? (cnt_dec == '0) : (cnt_dec[NARROW_W-1:0] == '0);
        init_zero    = addr_wide ? (cnt_init == '0) : (cnt_init[NARROW_W-1:0] == '0);
        go_on        = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.src   = src_init;
                    d.dst   = dst_init;
                    d.cnt   = cnt_init;
                    d.size  = elem_sz;
                    d.wide  = addr_wide;
                    d.down  = dir_down;
                    d.rep   = rep_mode;
                    d.fault = 1'b0;
                    if (((rep_mode == RP_EQ) || (rep_mode == RP_NE)) && init_zero) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (|oob) begin
                    d.fault = 1'b1;
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.opa = '0;
                    d.opb = '0;
                    d.k   = '0;
                    d.st  = ST_RD_SRC;
                end
            end
            ST_RD_SRC: begin
                if (mem_ready) begin
                    d.opa[{q.k, 3'b000} +: 8] = mem_rdata;
                    d.k = q.k + K_W'(1);
                    if (last_byte) begin
                        d.k  = '0;
                        d.st = ST_RD_DST;
                    end
                end
            end
            ST_RD_DST: begin
                if (mem_ready) begin
                    d.opb[{q.k, 3'b000} +: 8] = mem_rdata;
                    d.k = q.k + K_W'(1);
                    if (last_byte) begin
                        d.k  = '0;
                        d.st = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                d.flags = alu_flags;
                d.src   = idx_nxt[0];
                d.dst   = idx_nxt[1];
                if (rep_on) d.cnt = cnt_dec;
                go_on = rep_on && !cnt_dec_zero &&
                        ((q.rep == RP_EQ) ? alu_flags[FL_ZF] : !alu_flags[FL_ZF]);
                if (go_on) begin
                    d.st = ST_CHECK;
                end else begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_w  = (q.st != ST_IDLE);
    assign a32_w   = q.wide;
    assign src_idx = q.src;
    assign dst_idx = q.dst;
    assign cnt     = q.cnt;
    assign flags   = q.flags;
    assign done    = q.done;
    assign fault   = q.fault;

endmodule

// File: rtl/strcmp_unit_chk.sv
module strcmp_unit_chk #(
    parameter int IDX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       rep_mode,
    input logic             addr_wide,
    input logic [IDX_W-1:0] cnt_init,
    input logic             mem_req,
    input logic             mem_ready,
    input logic [IDX_W-1:0] mem_addr,
    input logic [IDX_W-1:0] src_idx,
    input logic [IDX_W-1:0] dst_idx,
    input logic [IDX_W-1:0] cnt,
    input logic             done,
    input logic             fault,
    input logic             busy,
    input logic             cfg_wide
);

    p_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    p_narrow_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !cfg_wide) |-> (mem_addr[IDX_W-1:16] == '0));

    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !cfg_wide) |=> ($stable(src_idx[IDX_W-1:16]) &&
                                   $stable(dst_idx[IDX_W-1:16]) &&
                                   $stable(cnt[IDX_W-1:16])));

    p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (rep_mode == 2'd1 || rep_mode == 2'd2) &&
         (addr_wide ? (cnt_init == '0) : (cnt_init[15:0] == '0)))
        |=> (done && !mem_req && !busy));

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind strcmp_unit strcmp_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rep_mode  (rep_mode),
    .addr_wide (addr_wide),
    .cnt_init  (cnt_init),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .cnt       (cnt),
    .done      (done),
    .fault     (fault),
    .busy      (busy_w),
    .cfg_wide  (a32_w)
);

// File: tb/strcmp_unit_bench.sv
module strcmp_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, start, addr_wide, dir_down, mem_req, mem_ready, done, fault;
    logic [1:0]  elem_sz, rep_mode;
    logic [31:0] src_init, dst_init, cnt_init, mem_addr, src_idx, dst_idx, cnt;
    logic [7:0]  mem_rdata;
    logic [5:0]  flags;

    logic [7:0]  mem [0:4095];
    int          n_chk = 0, n_err = 0, acc = 0;
    logic [5:0]  e_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strcmp_unit u_strcmp_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_sz(elem_sz),
        .addr_wide(addr_wide), .dir_down(dir_down), .rep_mode(rep_mode),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .src_idx(src_idx), .dst_idx(dst_idx),
        .cnt(cnt), .flags(flags), .done(done), .fault(fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] elem(input logic [31:0] idx, input int nb);
        logic [31:0] v = '0;
        for (int i = 0; i < nb; i++) begin
            logic [31:0] a = idx + 32'(i);
            v = v | (32'(mem[a[11:0]]) << (8 * i));
        end
        return v;
    endfunction

    function automatic logic [5:0] ref_flags(input logic [31:0] av, input logic [31:0] bv,
                                             input int nb);
        longint one = 1;
        longint w = 8 * nb;
        longint m = (one << w) - 1;
        longint a = longint'(av) & m;
        longint b = longint'(bv) & m;
        longint r = (a - b) & m;
        longint half = one << (w - 1);
        longint sa = (a >= half) ? a - (one << w) : a;
        longint sb = (b >= half) ? b - (one << w) : b;
        longint sd = sa - sb;
        bit of = (sd < -half) || (sd >= half);
        bit pf = ~^r[7:0];
        return {of, r >= half, r == 0, (a & 15) < (b & 15), pf, a < b};
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] idx, input int nb,
                                        input bit down, input bit wide);
        logic [31:0] s = down ? 32'(-nb) : 32'(nb);
        if (wide) return idx + s;
        return {idx[31:16], 16'(idx[15:0] + s[15:0])};
    endfunction

    function automatic bit oob(input logic [31:0] idx, input int nb, input bit wide);
        return !wide && ((int'(idx[15:0]) + nb - 1) > 65535);
    endfunction

    task automatic copy(input logic [31:0] s, input logic [31:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a = s + 32'(i);
            logic [31:0] b = d + 32'(i);
            mem[b[11:0]] = mem[a[11:0]];
        end
    endtask

    task automatic run(input logic [1:0] sz, input bit wide, input bit down,
                       input logic [1:0] rep, input logic [31:0] s0,
                       input logic [31:0] d0, input logic [31:0] c0, input bit poke);
        int          nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        bit          repon = (rep == 2'd1) || (rep == 2'd2);
        logic [31:0] s = s0, d = d0, c = c0;
        logic [5:0]  f = e_flags;
        bit          flt = 0, go, zc;
        int          t = 0;
        zc = wide ? (c0 == 0) : (c0[15:0] == 0);
        go = !(repon && zc);
        while (go) begin
            if (oob(s, nb, wide) || oob(d, nb, wide)) begin flt = 1; break; end
            f = ref_flags(elem(s, nb), elem(d, nb), nb);
            s = adv(s, nb, down, wide);
            d = adv(d, nb, down, wide);
            if (!repon) break;
            c = wide ? c - 1 : {c[31:16], 16'(c[15:0] - 16'd1)};
            if (wide ? (c == 0) : (c[15:0] == 0)) break;
            if (rep == 2'd1 && !f[3]) break;
            if (rep == 2'd2 && f[3]) break;
        end
        e_flags = f;
        @(negedge clk);
        elem_sz = sz; addr_wide = wide; dir_down = down; rep_mode = rep;
        src_init = s0; dst_init = d0; cnt_init = c0; start = 1'b1; acc = 0;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R8: a second start during the run must have no effect
            repeat (2) @(negedge clk);
            start = 1'b1; src_init = ~s0; dst_init = ~d0; cnt_init = 32'd7;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(done === 1'b1, "R8 done seen", 32'(done), 32'd1);
        chk(src_idx === s, "R3 src index", src_idx, s);
        chk(dst_idx === d, "R3 dst index", dst_idx, d);
        chk(cnt === c, "R5 count", cnt, c);
        chk(flags === f, "R1,R2 flags", 32'(flags), 32'(f));
        chk(fault === flt, "R7 fault", 32'(fault), 32'(flt));
        if (!wide) chk(src_idx[31:16] === s0[31:16] && cnt[31:16] === c0[31:16],
                       "R4 upper bits", {src_idx[31:16], cnt[31:16]}, {s0[31:16], c0[31:16]});
        if (repon && zc) chk(acc == 0, "R6 no reads", 32'(acc), 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", 32'(done), 32'd0);
    endtask

    // memory model with random wait states
    initial begin
        int          wait_left = 0;
        bit          was_wait = 0;
        logic [31:0] prev_addr = '0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && was_wait)
                chk(mem_addr === prev_addr, "R9 address held", mem_addr, prev_addr);
            if (mem_req) begin
                if (wait_left == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem[mem_addr[11:0]];
                    acc++;
                    wait_left = int'($urandom % 3);
                    was_wait  = 0;
                end else begin
                    mem_ready = 1'b0;
                    wait_left--;
                    was_wait  = 1;
                end
            end else begin
                mem_ready = 1'b0;
                was_wait  = 0;
            end
            prev_addr = mem_addr;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; start = 1'b0; elem_sz = '0; addr_wide = 1'b0; dir_down = 1'b0;
        rep_mode = '0; src_init = '0; dst_init = '0; cnt_init = '0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && fault === 1'b0 && mem_req === 1'b0, "R8 reset idle",
            {29'd0, done, fault, mem_req}, 32'd0);
        chk(src_idx === 0 && dst_idx === 0 && cnt === 0 && flags === 0, "R2 reset regs",
            src_idx | dst_idx | cnt | 32'(flags), 32'd0);
        rst_n = 1'b1;

        // R2: equal bytes, zero result
        mem[100] = 8'h40; mem[2100] = 8'h40;
        run(2'd0, 1, 0, 2'd0, 32'd100, 32'd2100, 32'd5, 0);
        // R2: signed overflow, 0x80 - 0x01
        mem[101] = 8'h80; mem[2101] = 8'h01;
        run(2'd0, 1, 0, 2'd0, 32'd101, 32'd2101, 32'd5, 0);
        // R1: little-endian word with borrow
        mem[200] = 8'h34; mem[201] = 8'h12; mem[2200] = 8'h35; mem[2201] = 8'h12;
        run(2'd1, 0, 0, 2'd0, 32'h7777_00C8, 32'h0000_0898, 32'd1, 0);
        // R5: repeat while equal, dwords, mismatch at sixth element
        copy(32'h300, 32'hA00, 24);
        mem[12'hA14] = mem[12'h314] ^ 8'h01;
        run(2'd2, 1, 0, 2'd1, 32'h1000_0300, 32'h2000_0A00, 32'd10, 0);
        // R5: repeat while unequal, bytes, downward, match at fourth element
        for (int i = 0; i < 6; i++) mem[12'hC00 - 12'(i)] = mem[12'h400 - 12'(i)] ^ 8'h5A;
        mem[12'hBFD] = mem[12'h3FD];
        run(2'd0, 0, 1, 2'd2, 32'h0000_0400, 32'h0000_0C00, 32'd6, 0);
        // R6: zero count in narrow mode (upper bits nonzero)
        run(2'd1, 0, 0, 2'd1, 32'd10, 32'd20, 32'hABCD_0000, 0);
        // R7: dword straddles 0xFFFF in narrow mode
        run(2'd2, 0, 0, 2'd0, 32'h1234_FFFE, 32'd40, 32'd1, 0);
        // R4: narrow downward wrap through zero
        mem[12'h001] = mem[12'h502]; mem[12'h000] = mem[12'h501]; mem[12'hFFF] = mem[12'h500];
        run(2'd0, 0, 1, 2'd1, 32'h0001_0001, 32'h0002_0502, 32'h5555_0003, 0);
        // R8: start during a run is ignored
        run(2'd2, 1, 0, 2'd0, 32'h0000_0600, 32'h0000_0E00, 32'd3, 1);

        for (int n = 0; n < 60; n++) begin
            logic [1:0]  sz = 2'($urandom % 3);
            bit          wide = 1'($urandom);
            bit          down = 1'($urandom);
            logic [1:0]  rep = 2'($urandom);
            logic [31:0] s = $urandom, d = $urandom, c = $urandom % 9;
            if (!wide) begin
                c[31:16] = 16'($urandom);
                if ($urandom % 4 == 0) s[15:0] = 16'hFFF0 | 16'($urandom % 16);
            end
            if ($urandom % 2 == 0) copy(s - 32'd40, d - 32'd40, 80);
            run(sz, wide, down, rep, s, d, c, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule